// File: doc/BRIEF.md
# SMBus Packet Error Check Engine

This block sits beside the byte shifter of an I2C target and adds SMBus packet error checking to it. Each time the shifter moves one bit across the bus, address or data, it gives the engine a strobe. The engine folds that bit into a bit-serial CRC-8. It also counts data bytes against a segment length that software programs. ACK/NACK slots and START/STOP conditions never reach the engine, so they never enter the checksum.

In transmit direction the engine watches which byte the shifter is about to load. When that byte is the last one of a segment, it replaces the dummy byte from the transmit queue with the running checksum. In receive direction it inspects the checksum residue right after the last bit of the segment's final byte. A nonzero residue raises a one-cycle error pulse and a NACK request for the acknowledge slot that follows. The received checksum byte still travels on to the receive path. After a checksum byte the counter and the CRC restart, so one transaction may hold several checked segments. While the bus is idle, everything is cleared.

Top module: `smb_pec_engine`

## Requirements
- R1: The checksum is CRC-8 with polynomial x^8+x^2+x+1 (0x07). It starts at 0x00 and is updated MSB-first with one bit for every bit_stb, for both address bytes and data bytes.
- R2: Address bytes (byte_is_data=0) enter the checksum but do not advance the byte count.
- R3: While bus_idle is high, the checksum and the byte count clear and nack_req drops. A segment that was interrupted therefore leaves no trace in the next transaction.
- R4: When pec_on=0, or when seg_len=0, tx_byte equals fifo_byte, tx_pec_slot stays 0, and no error or NACK request is produced.
- R5: With tx_mode=1, the data byte whose 1-based position in the segment equals seg_len is presented on tx_byte as the current checksum, with tx_pec_slot=1. Every other data byte passes fifo_byte through unchanged.
- R6: With tx_mode=0, the cycle after the last bit (bit_last=1) of the seg_len-th data byte, pec_err pulses high for exactly one cycle if the checksum including that byte is nonzero, and stays low if it is zero. In transmit mode pec_err never fires.
- R7: nack_req rises together with pec_err. It stays high until the next bit_stb or until bus_idle.
- R8: After the checksum byte, the count and the checksum restart from zero inside the same transaction, so a second segment is checked on its own bytes only.
- R9: A change to seg_len during a transaction takes effect at the next byte boundary and does not clear the running checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pec_on | input | 1 | Enables checksum generation and checking |
| seg_len | input | CNT_W (9) | Data bytes per segment including the checksum byte; 0 disables counting |
| bus_idle | input | 1 | Target controller is idle (after STOP or timeout) |
| tx_mode | input | 1 | 1 = target drives data bytes, 0 = target receives |
| bit_stb | input | 1 | One address or data bit has crossed the bus |
| bit_val | input | 1 | Value of the bit qualified by bit_stb |
| bit_last | input | 1 | The strobed bit is bit 0 of its byte |
| byte_is_data | input | 1 | Current byte is a data byte (0 = address byte) |
| fifo_byte | input | CRC_W (8) | Next byte from the transmit queue |
| tx_byte | output | CRC_W (8) | Byte to load into the transmit shifter |
| tx_pec_slot | output | 1 | tx_byte carries the checksum instead of fifo_byte |
| pec_err | output | 1 | One-cycle receive checksum error pulse |
| nack_req | output | 1 | Request to answer the current byte with NACK |

## Verification
The bench builds the engine with its default parameters: an 8-bit MSB-first CRC and a 9-bit segment counter. At this size a single-byte segment can be swept through all 256 received checksum values after a fixed address, which checks that exactly one value passes and that every other value yields the error pulse and the NACK. Segment lengths one to four are also driven in transmit direction twice within one transaction, with the expected checksum computed by a byte-wise model in the bench, so the substitution position and the restart between segments both come under test.

// File: rtl/pec_pkg.sv
package pec_pkg;

   // Outcome of a data byte boundary, as seen by the receive checker
   typedef enum logic [1:0] {
      SEG_NONE = 2'd0,  // not the last byte of a segment
      SEG_PASS = 2'd1,  // segment closed with zero residue
      SEG_FAIL = 2'd2   // segment closed with nonzero residue
   } seg_evt_e;

   // Bit-reverse a polynomial constant for the LSB-first variant
   function automatic logic [31:0] reflect32(input logic [31:0] v, input int w);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < w; i++) begin
         r[w-1-i] = v[i];
      end
      return r;
   endfunction

endpackage

// File: rtl/pec_crc_lfsr.sv
module pec_crc_lfsr #(
   parameter int           W         = 8,
   parameter logic [W-1:0] POLY      = 8'h07,
   parameter bit           MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic         din,
   output logic [W-1:0] crc_q,
   output logic [W-1:0] crc_nxt
);
   import pec_pkg::*;

   if (W < 2) begin : g_bad_width
      $error("pec_crc_lfsr: W must be at least 2");
   end

   if (MSB_FIRST) begin : g_msb
      logic fb;
      always_comb begin
         fb      = crc_q[W-1] ^ din;
         crc_nxt = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   end else begin : g_lsb
      localparam logic [W-1:0] POLY_R = W'(reflect32(32'(POLY), W));
      logic fb;
      always_comb begin
         fb      = crc_q[0] ^ din;
         crc_nxt = (crc_q >> 1) ^ (fb ? POLY_R : '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
      end else if (clr) begin
         crc_q <= '0;
      end else if (step) begin
         crc_q <= crc_nxt;
      end
   end

   // A zero bit shifted into a zero register keeps it zero
   AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !din && crc_q == '0) |=> (crc_q == '0)); // R1

   // Clearing always wins over stepping
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (crc_q == '0)); // R3

endmodule

// File: rtl/pec_seg_counter.sv
module pec_seg_counter #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             byte_end,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt_q,
   output logic             is_pec
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pec_seg_counter: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt_inc;

   always_comb begin
      cnt_inc = cnt_q + 1'b1;
      is_pec  = (limit != '0) && (cnt_inc == limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (byte_end) begin
         cnt_q <= is_pec ? '0 : cnt_inc;
      end
   end

   AST_SEG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && is_pec) |=> (cnt_q == '0)); // R8

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_end && !clr) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/pec_tx_mux.sv
module pec_tx_mux #(
   parameter int W = 8
) (
   input  logic         sel_crc,
   input  logic [W-1:0] crc,
   input  logic [W-1:0] queued,
   output logic [W-1:0] out_byte
);
   always_comb begin
      out_byte = sel_crc ? crc : queued;
   end
endmodule

// File: rtl/smb_pec_engine.sv
module smb_pec_engine #(
   parameter int               CRC_W     = 8,
   parameter logic [CRC_W-1:0] CRC_POLY  = 8'h07,
   parameter bit               MSB_FIRST = 1'b1,
   parameter int               CNT_W     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pec_on,
   input  logic [CNT_W-1:0] seg_len,
   input  logic             bus_idle,
   input  logic             tx_mode,
   input  logic             bit_stb,
   input  logic             bit_val,
   input  logic             bit_last,
   input  logic             byte_is_data,
   input  logic [CRC_W-1:0] fifo_byte,
   output logic [CRC_W-1:0] tx_byte,
   output logic             tx_pec_slot,
   output logic             pec_err,
   output logic             nack_req
);
   import pec_pkg::*;

   if (CRC_W != 8 && CRC_POLY == '0) begin : g_bad_poly
      $error("smb_pec_engine: polynomial must be nonzero");
   end

   logic [CRC_W-1:0] crc_q, crc_nxt;
   logic [CNT_W-1:0] cnt_q;
   logic             seg_pec;
   logic             data_end, seg_close, crc_clr, cnt_clr;
   seg_evt_e         seg_evt;

   always_comb begin
      data_end  = pec_on && bit_stb && bit_last && byte_is_data;
      seg_close = data_end && seg_pec;
      cnt_clr   = bus_idle || !pec_on;
      crc_clr   = cnt_clr || seg_close;
      if (!seg_close || tx_mode) begin
         seg_evt = SEG_NONE;
      end else if (crc_nxt != '0) begin
         seg_evt = SEG_FAIL;
      end else begin
         seg_evt = SEG_PASS;
      end
      tx_pec_slot = pec_on && tx_mode && seg_pec;
   end

   pec_crc_lfsr #(
      .W(CRC_W), .POLY(CRC_POLY), .MSB_FIRST(MSB_FIRST)
   ) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(crc_clr),
      .step(pec_on && bit_stb), .din(bit_val),
      .crc_q(crc_q), .crc_nxt(crc_nxt)
   );

   pec_seg_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr),
      .byte_end(data_end), .limit(seg_len),
      .cnt_q(cnt_q), .is_pec(seg_pec)
   );

   pec_tx_mux #(
      .W(CRC_W)
   ) u_mux (
      .sel_crc(tx_pec_slot), .crc(crc_q),
      .queued(fifo_byte), .out_byte(tx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pec_err  <= 1'b0;
         nack_req <= 1'b0;
      end else begin
         pec_err <= (seg_evt == SEG_FAIL);
         if (cnt_clr) begin
            nack_req <= 1'b0;
         end else if (seg_evt == SEG_FAIL) begin
            nack_req <= 1'b1;
         end else if (bit_stb) begin
            nack_req <= 1'b0;
         end
      end
   end

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pec_err |=> !pec_err); // R6

   AST_TX_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      tx_mode |=> !pec_err); // R6

   AST_ERR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      pec_err |-> nack_req); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_idle |=> (!nack_req && !pec_err && cnt_q == '0 && crc_q == '0)); // R3

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pec_on |=> !pec_err); // R4

   AST_NO_LEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_len == '0) |=> !pec_err); // R4

   AST_ADDR_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !byte_is_data && !bus_idle) |=> $stable(cnt_q)); // R2

endmodule

// File: tb/test_smb_pec_engine.sv
module test_smb_pec_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pec_on = 1'b0;
   logic [8:0] seg_len = '0;
   logic       bus_idle = 1'b1;
   logic       tx_mode = 1'b0;
   logic       bit_stb = 1'b0;
   logic       bit_val = 1'b0;
   logic       bit_last = 1'b0;
   logic       byte_is_data = 1'b0;
   logic [7:0] fifo_byte = '0;
   logic [7:0] tx_byte;
   logic       tx_pec_slot, pec_err, nack_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   smb_pec_engine i_smb_pec_engine (
      .clk(clk), .rst_n(rst_n), .pec_on(pec_on), .seg_len(seg_len),
      .bus_idle(bus_idle), .tx_mode(tx_mode), .bit_stb(bit_stb),
      .bit_val(bit_val), .bit_last(bit_last), .byte_is_data(byte_is_data),
      .fifo_byte(fifo_byte), .tx_byte(tx_byte), .tx_pec_slot(tx_pec_slot),
      .pec_err(pec_err), .nack_req(nack_req)
   );

   // Byte-wise CRC-8 model, polynomial 0x07
   function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
      logic [7:0] r;
      r = c ^ b;
      for (int k = 0; k < 8; k++) begin
         r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit is_data);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         bit_stb      = 1'b1;
         bit_val      = b[7-i];
         bit_last     = (i == 7);
         byte_is_data = is_data;
      end
      @(negedge clk);
      bit_stb  = 1'b0;
      bit_last = 1'b0;
   endtask

   task automatic idle_gap();
      @(negedge clk);
      bus_idle = 1'b1;
      @(negedge clk);
      bus_idle = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] m;
      logic [7:0] exp_b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      fifo_byte = 8'hA5;
      #1;
      // Reset state: pass-through, quiet outputs (R4)
      check(tx_byte == 8'hA5, "R4 reset tx_byte", tx_byte, 8'hA5);
      check(!pec_err && !nack_req && !tx_pec_slot, "R4 reset quiet",
            {pec_err, nack_req, tx_pec_slot}, 0);

      // Exhaustive sweep of a one-byte receive segment (R1 R6 R7 R3)
      pec_on  = 1'b1;
      seg_len = 9'd1;
      tx_mode = 1'b0;
      for (int v = 0; v < 256; v++) begin
         bit exp_e;
         idle_gap();
         send_byte(8'h20, 1'b0);
         send_byte(8'(v), 1'b1);
         exp_e = (crc_byte(crc_byte(8'h00, 8'h20), 8'(v)) != 8'h00);
         check(pec_err == exp_e, "R6 residue check", pec_err, exp_e);
         check(nack_req == exp_e, "R7 nack with error", nack_req, exp_e);
         @(negedge clk);
         check(!pec_err, "R6 one-cycle pulse", pec_err, 0);
         check(nack_req == exp_e, "R7 nack held", nack_req, exp_e);
         idle_gap();
         check(!nack_req, "R3 idle drops nack", nack_req, 0);
      end

      // Transmit segments of length 1..4, two per transaction (R5 R8 R2)
      tx_mode = 1'b1;
      for (int n = 1; n <= 4; n++) begin
         seg_len = 9'(n);
         idle_gap();
         m = crc_byte(8'h00, 8'h21);
         send_byte(8'h21, 1'b0);
         for (int s = 0; s < 2; s++) begin
            for (int k = 1; k <= n; k++) begin
               @(negedge clk);
               fifo_byte = 8'h3C + 8'(k) + 8'(16 * s);
               #1;
               exp_b = (k == n) ? m : fifo_byte;
               check(tx_byte == exp_b, "R5 tx byte", tx_byte, exp_b);
               check(tx_pec_slot == (k == n), "R5 tx slot flag", tx_pec_slot, (k == n));
               send_byte(tx_byte, 1'b1);
               check(!pec_err, "R6 tx never errors", pec_err, 0);
               m = (k == n) ? 8'h00 : crc_byte(m, exp_b);  // R8 restart
            end
         end
      end

      // Disabled engine / zero length: pass-through, no error (R4)
      tx_mode = 1'b1;
      seg_len = 9'd1;
      pec_on  = 1'b0;
      idle_gap();
      @(negedge clk);
      fifo_byte = 8'h5A;
      #1;
      check(tx_byte == 8'h5A && !tx_pec_slot, "R4 disabled tx", tx_byte, 8'h5A);
      pec_on  = 1'b1;
      seg_len = 9'd0;
      #1;
      check(tx_byte == 8'h5A && !tx_pec_slot, "R4 zero length tx", tx_byte, 8'h5A);
      tx_mode = 1'b0;
      for (int e = 0; e < 2; e++) begin
         pec_on  = (e == 1);
         seg_len = (e == 1) ? 9'd0 : 9'd1;
         idle_gap();
         send_byte(8'h20, 1'b0);
         send_byte(8'h00, 1'b1);
         check(!pec_err && !nack_req, "R4 no check when off", pec_err, 0);
      end

      // Interrupted segment cleared by idle (R3)
      pec_on  = 1'b1;
      seg_len = 9'd2;
      idle_gap();
      send_byte(8'h20, 1'b0);
      send_byte(8'h55, 1'b1);
      idle_gap();
      send_byte(8'h20, 1'b0);
      send_byte(8'h77, 1'b1);
      m = crc_byte(crc_byte(8'h00, 8'h20), 8'h77);
      send_byte(m, 1'b1);
      check(!pec_err, "R3 fresh segment after idle", pec_err, 0);

      // Length changed mid-segment, checksum kept (R9)
      for (int g = 0; g < 2; g++) begin
         seg_len = 9'd5;
         idle_gap();
         send_byte(8'h20, 1'b0);
         send_byte(8'h11, 1'b1);
         seg_len = 9'd2;
         m = crc_byte(crc_byte(8'h00, 8'h20), 8'h11);
         send_byte((g == 0) ? m : ~m, 1'b1);
         check(pec_err == (g == 1), "R9 new length at boundary", pec_err, (g == 1));
         if (g == 1) begin
            send_byte(8'h42, 1'b1);
            check(!nack_req && !pec_err, "R7 nack dropped by next bits", nack_req, 0);
         end
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule